// File: doc/BRIEF.md
# Machine-Mode Trap State Unit

This unit keeps the machine-level trap context of a small RISC-V style core. It holds the exception PC, the live global interrupt enable, the copy of that enable saved at trap entry, the individual interrupt enables and the trap vector base. The pipeline sends a one-cycle entry strobe together with the PC of the instruction being trapped. The unit then saves that PC, moves the live enable into the saved slot, and clears the live enable so that no further interrupts are taken. A one-cycle return strobe copies the saved enable back into the live enable. The exception PC is always presented as the fetch redirect target, so the fetch stage reads it in the same cycle as the return.

A non-maskable interrupt entry also pushes the current exception PC and saved enable into a one-deep backup that software cannot reach, and it sets an NMI-mode flag. While that flag is set, every entry strobe is ignored. The return that leaves NMI mode pops the backup into the visible registers, so the handler that was interrupted gets its context back. Software reaches the visible registers through a CSR port with a combinational read and a synchronous write.

Top module: `mtrap_state`

## Requirements
- R1: After reset the exception PC, live enable, saved enable, individual enables and NMI-mode flag are all 0. The vector base equals the boot address with its low 8 bits forced to 0.
- R2: An accepted entry strobe loads the exception PC with `trap_pc_i` at the next clock edge.
- R3: An accepted entry strobe copies the live enable into the saved enable and clears the live enable.
- R4: `ret_target_o` always equals the exception PC. A return strobe outside NMI mode copies the saved enable into the live enable and sets the saved enable to 1. This holds even when no trap is in progress.
- R5: CSR map, with reads combinational and writes taking effect at the next edge:
  - 0x300 is status, with the live enable at bit 3 and the saved enable at bit 7; all other bits read 0.
  - 0x304 holds the individual enables in the low NIRQ bits.
  - 0x305 is the vector base.
  - 0x341 is the exception PC.
  - Any other address reads 0 and ignores writes.
- R6: A write to the vector base stores the written value with its low 8 bits forced to 0.
- R7: Entry beats a return strobe and a CSR write in the same cycle. A return beats a CSR write in the same cycle. The losing event has no effect.
- R8: An accepted entry with `trap_nmi_i` high pushes the exception PC and saved enable into the hidden backup and sets the NMI-mode flag. Its other effects are those of R2 and R3.
- R9: While the NMI-mode flag is set, entry strobes (NMI or not) change no state.
- R10: A return strobe in NMI mode copies the saved enable into the live enable, restores the exception PC and saved enable from the backup, and clears the NMI-mode flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_addr_i | input | XLEN | Boot address, sampled into the vector base during reset |
| trap_enter_i | input | 1 | Trap entry strobe |
| trap_nmi_i | input | 1 | Marks the entry as a non-maskable interrupt |
| trap_pc_i | input | XLEN | PC saved on entry |
| trap_ret_i | input | 1 | Trap return strobe |
| csr_we_i | input | 1 | CSR write enable |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data |
| epc_o | output | XLEN | Exception PC |
| ret_target_o | output | XLEN | Fetch redirect target for a return |
| gie_o | output | 1 | Live global interrupt enable |
| irq_en_o | output | NIRQ | Individual interrupt enables |
| vec_base_o | output | XLEN | Trap vector base |
| nmi_mode_o | output | 1 | NMI-mode flag |

## Verification
On every cycle, the assertions check the register updates that follow each event:
- the PC captured on entry;
- the enable shuffle on entry and on return;
- the push into the backup and the pop out of it;
- the vector base and enable writes;
- entry winning over a concurrent write;
- entries having no effect in NMI mode.

Some behaviour only the bench's scenarios can show, because it depends on the whole CSR view and on a model of the state:
- the reset values;
- the CSR bit layout and unmapped addresses;
- a return with no trap pending;
- a normal trap, then an NMI, then both returns, ending with the first handler's PC restored.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
   localparam logic [11:0] CSR_STATUS = 12'h300;
   localparam logic [11:0] CSR_IE     = 12'h304;
   localparam logic [11:0] CSR_VEC    = 12'h305;
   localparam logic [11:0] CSR_EPC    = 12'h341;
   localparam int STAT_GIE_BIT = 3;
   localparam int STAT_PIE_BIT = 7;

   typedef enum logic [1:0] {
      EV_NONE   = 2'd0,
      EV_ENTER  = 2'd1,
      EV_RETURN = 2'd2,
      EV_WRITE  = 2'd3
   } trap_ev_e;
endpackage

// File: rtl/mtrap_status.sv
module mtrap_status
   import mtrap_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  trap_ev_e ev_i,
   input  logic     nmi_entry_i,
   input  logic     wr_en_i,
   input  logic     wr_gie_i,
   input  logic     wr_pie_i,
   input  logic     bk_pie_i,
   output logic     gie_o,
   output logic     pie_o,
   output logic     nmi_mode_o
);
   logic gie_q, pie_q, nmi_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gie_q <= 1'b0;
         pie_q <= 1'b0;
         nmi_q <= 1'b0;
      end else begin
         case (ev_i)
            EV_ENTER: begin
               pie_q <= gie_q;
               gie_q <= 1'b0;
               if (nmi_entry_i) nmi_q <= 1'b1;
            end
            EV_RETURN: begin
               gie_q <= pie_q;
               pie_q <= nmi_q ? bk_pie_i : 1'b1;
               nmi_q <= 1'b0;
            end
            EV_WRITE: begin
               if (wr_en_i) begin
                  gie_q <= wr_gie_i;
                  pie_q <= wr_pie_i;
               end
            end
            default: ;
         endcase
      end
   end

   assign gie_o      = gie_q;
   assign pie_o      = pie_q;
   assign nmi_mode_o = nmi_q;

   // R3: entry saves the live enable and blocks further interrupts
   assert_entry_clears_gie_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_i == EV_ENTER) |=> (!gie_q && pie_q == $past(gie_q)));

   // R4 / R10: return moves the saved enable back into the live enable
   assert_return_restores_gie_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_i == EV_RETURN) |=> (gie_q == $past(pie_q)));

   // R4: return outside NMI mode leaves the saved enable at 1
   assert_return_sets_pie_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_i == EV_RETURN && !nmi_q) |=> pie_q);

   // R10: return from NMI mode clears the flag
   assert_nmi_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_i == EV_RETURN && nmi_q) |=> (!nmi_q && pie_q == $past(bk_pie_i)));
endmodule

// File: rtl/mtrap_epc_stack.sv
module mtrap_epc_stack
   import mtrap_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit NMI_BACKUP = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  trap_ev_e        ev_i,
   input  logic            nmi_entry_i,
   input  logic            nmi_mode_i,
   input  logic [XLEN-1:0] trap_pc_i,
   input  logic            wr_en_i,
   input  logic [XLEN-1:0] wdata_i,
   input  logic            pie_i,
   output logic [XLEN-1:0] epc_o,
   output logic            bk_pie_o
);
   logic [XLEN-1:0] epc_q;
   logic [XLEN-1:0] bk_epc_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         epc_q <= '0;
      end else begin
         case (ev_i)
            EV_ENTER:  epc_q <= trap_pc_i;
            EV_RETURN: if (nmi_mode_i) epc_q <= bk_epc_w;
            EV_WRITE:  if (wr_en_i) epc_q <= wdata_i;
            default: ;
         endcase
      end
   end

   generate
      if (NMI_BACKUP) begin : g_backup
         logic [XLEN-1:0] bk_epc_q;
         logic            bk_pie_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               bk_epc_q <= '0;
               bk_pie_q <= 1'b0;
            end else if (ev_i == EV_ENTER && nmi_entry_i) begin
               bk_epc_q <= epc_q;
               bk_pie_q <= pie_i;
            end
         end
         assign bk_epc_w = bk_epc_q;
         assign bk_pie_o = bk_pie_q;

         // R8: NMI entry pushes the interrupted context
         assert_nmi_push_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ev_i == EV_ENTER && nmi_entry_i) |=>
               (bk_epc_q == $past(epc_q) && bk_pie_q == $past(pie_i)));
      end else begin : g_no_backup
         assign bk_epc_w = epc_q;
         assign bk_pie_o = 1'b1;
      end
   endgenerate

   assign epc_o = epc_q;

   // R2: accepted entry captures the trapping PC
   assert_entry_epc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_i == EV_ENTER) |=> (epc_q == $past(trap_pc_i)));

   // R10: leaving NMI mode pops the saved PC
   assert_nmi_pop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_i == EV_RETURN && nmi_mode_i) |=> (epc_q == $past(bk_epc_w)));
endmodule

// File: rtl/mtrap_cfg_regs.sv
module mtrap_cfg_regs #(
   parameter int XLEN      = 32,
   parameter int NIRQ      = 16,
   parameter int VEC_ALIGN = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [XLEN-1:0] boot_addr_i,
   input  logic            vec_we_i,
   input  logic            ie_we_i,
   input  logic [XLEN-1:0] wdata_i,
   output logic [XLEN-1:0] vec_o,
   output logic [NIRQ-1:0] ie_o
);
   localparam int VEC_HI_W = XLEN - VEC_ALIGN;

   logic [VEC_HI_W-1:0] vec_hi_q;
   logic [NIRQ-1:0]     ie_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vec_hi_q <= boot_addr_i[XLEN-1:VEC_ALIGN];
         ie_q     <= '0;
      end else begin
         if (vec_we_i) vec_hi_q <= wdata_i[XLEN-1:VEC_ALIGN];
         if (ie_we_i)  ie_q     <= wdata_i[NIRQ-1:0];
      end
   end

   assign vec_o = {vec_hi_q, {VEC_ALIGN{1'b0}}};
   assign ie_o  = ie_q;

   // R6: the vector base keeps the written upper bits
   assert_vec_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_we_i |=> (vec_o[XLEN-1:VEC_ALIGN] == $past(wdata_i[XLEN-1:VEC_ALIGN])));

   // R5: individual enables take the low write bits
   assert_ie_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ie_we_i |=> (ie_o == $past(wdata_i[NIRQ-1:0])));
endmodule

// File: rtl/mtrap_state.sv
module mtrap_state
   import mtrap_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NIRQ       = 16,
   parameter int VEC_ALIGN  = 8,
   parameter bit NMI_BACKUP = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [XLEN-1:0] boot_addr_i,
   input  logic            trap_enter_i,
   input  logic            trap_nmi_i,
   input  logic [XLEN-1:0] trap_pc_i,
   input  logic            trap_ret_i,
   input  logic            csr_we_i,
   input  logic [11:0]     csr_addr_i,
   input  logic [XLEN-1:0] csr_wdata_i,
   output logic [XLEN-1:0] csr_rdata_o,
   output logic [XLEN-1:0] epc_o,
   output logic [XLEN-1:0] ret_target_o,
   output logic            gie_o,
   output logic [NIRQ-1:0] irq_en_o,
   output logic [XLEN-1:0] vec_base_o,
   output logic            nmi_mode_o
);
   generate
      if (XLEN < 16 || XLEN > 64) begin : g_bad_xlen
         $error("mtrap_state: XLEN must lie in 16..64");
      end
      if (NIRQ < 1 || NIRQ > XLEN) begin : g_bad_nirq
         $error("mtrap_state: NIRQ must lie in 1..XLEN");
      end
      if (VEC_ALIGN < 2 || VEC_ALIGN >= XLEN) begin : g_bad_align
         $error("mtrap_state: VEC_ALIGN out of range");
      end
   endgenerate

   trap_ev_e ev;
   logic     enter_ok;
   logic     pie, bk_pie;
   logic     wr_status, wr_ie, wr_vec, wr_epc;

   assign enter_ok = trap_enter_i & ~nmi_mode_o;

   always_comb begin
      if (enter_ok)        ev = EV_ENTER;
      else if (trap_ret_i) ev = EV_RETURN;
      else if (csr_we_i)   ev = EV_WRITE;
      else                 ev = EV_NONE;
   end

   assign wr_status = (ev == EV_WRITE) && (csr_addr_i == CSR_STATUS);
   assign wr_ie     = (ev == EV_WRITE) && (csr_addr_i == CSR_IE);
   assign wr_vec    = (ev == EV_WRITE) && (csr_addr_i == CSR_VEC);
   assign wr_epc    = (ev == EV_WRITE) && (csr_addr_i == CSR_EPC);

   mtrap_status u_status (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ev_i        (ev),
      .nmi_entry_i (trap_nmi_i),
      .wr_en_i     (wr_status),
      .wr_gie_i    (csr_wdata_i[STAT_GIE_BIT]),
      .wr_pie_i    (csr_wdata_i[STAT_PIE_BIT]),
      .bk_pie_i    (bk_pie),
      .gie_o       (gie_o),
      .pie_o       (pie),
      .nmi_mode_o  (nmi_mode_o)
   );

   mtrap_epc_stack #(
      .XLEN       (XLEN),
      .NMI_BACKUP (NMI_BACKUP)
   ) u_epc (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ev_i        (ev),
      .nmi_entry_i (trap_nmi_i),
      .nmi_mode_i  (nmi_mode_o),
      .trap_pc_i   (trap_pc_i),
      .wr_en_i     (wr_epc),
      .wdata_i     (csr_wdata_i),
      .pie_i       (pie),
      .epc_o       (epc_o),
      .bk_pie_o    (bk_pie)
   );

   mtrap_cfg_regs #(
      .XLEN      (XLEN),
      .NIRQ      (NIRQ),
      .VEC_ALIGN (VEC_ALIGN)
   ) u_cfg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .boot_addr_i (boot_addr_i),
      .vec_we_i    (wr_vec),
      .ie_we_i     (wr_ie),
      .wdata_i     (csr_wdata_i),
      .vec_o       (vec_base_o),
      .ie_o        (irq_en_o)
   );

   assign ret_target_o = epc_o;

   always_comb begin
      csr_rdata_o = '0;
      case (csr_addr_i)
         CSR_STATUS: begin
            csr_rdata_o[STAT_GIE_BIT] = gie_o;
            csr_rdata_o[STAT_PIE_BIT] = pie;
         end
         CSR_IE:  csr_rdata_o[NIRQ-1:0] = irq_en_o;
         CSR_VEC: csr_rdata_o = vec_base_o;
         CSR_EPC: csr_rdata_o = epc_o;
         default: ;
      endcase
   end

   // R9: entries in NMI mode leave the visible state untouched
   assert_nmi_ignores_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nmi_mode_o && trap_enter_i && !trap_ret_i && !csr_we_i) |=>
         ($stable(epc_o) && $stable(gie_o) && nmi_mode_o));

   // R7: an accepted entry wins over a same-cycle status write
   assert_entry_beats_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trap_enter_i && !nmi_mode_o && csr_we_i) |=>
         (!gie_o && epc_o == $past(trap_pc_i)));
endmodule

// File: tb/mtrap_state_test.sv
`timescale 1ns/1ps
module mtrap_state_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] boot_addr = 32'h8000_1234;
   logic        t_en = 1'b0, t_nmi = 1'b0, t_ret = 1'b0, c_we = 1'b0;
   logic [31:0] t_pc = '0, c_wd = '0;
   logic [11:0] c_addr = 12'h300;
   logic [31:0] rdata, epc, rtgt, vec;
   logic        gie, nmi_mode;
   logic [15:0] ie;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   // behavioural reference state
   logic [31:0] m_epc, m_vec;
   logic        m_gie, m_pie, m_nmi;
   logic [15:0] m_ie;
   logic [31:0] bk_epc_q[$];
   logic        bk_pie_q[$];

   always #2.5 clk = ~clk;

   mtrap_state uut (
      .clk_i(clk), .rst_ni(rst_n), .boot_addr_i(boot_addr),
      .trap_enter_i(t_en), .trap_nmi_i(t_nmi), .trap_pc_i(t_pc), .trap_ret_i(t_ret),
      .csr_we_i(c_we), .csr_addr_i(c_addr), .csr_wdata_i(c_wd), .csr_rdata_o(rdata),
      .epc_o(epc), .ret_target_o(rtgt), .gie_o(gie), .irq_en_o(ie),
      .vec_base_o(vec), .nmi_mode_o(nmi_mode)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rdata(input logic [11:0] a);
      case (a)
         12'h300: return (32'(m_gie) << 3) | (32'(m_pie) << 7);
         12'h304: return {16'h0, m_ie};
         12'h305: return m_vec;
         12'h341: return m_epc;
         default: return 32'h0;
      endcase
   endfunction

   task automatic compare_all();
      chk("epc", epc, m_epc);
      chk("ret_target", rtgt, m_epc);
      chk("gie", {31'h0, gie}, {31'h0, m_gie});
      chk("nmi_mode", {31'h0, nmi_mode}, {31'h0, m_nmi});
      chk("vec_base", vec, m_vec);
      chk("irq_en", {16'h0, ie}, {16'h0, m_ie});
      chk("rdata", rdata, exp_rdata(c_addr));
   endtask

   task automatic model_step();
      if (t_en && !m_nmi) begin
         if (t_nmi) begin
            bk_epc_q.push_back(m_epc);
            bk_pie_q.push_back(m_pie);
            m_nmi = 1'b1;
         end
         m_pie = m_gie;
         m_gie = 1'b0;
         m_epc = t_pc;
      end else if (t_ret) begin
         m_gie = m_pie;
         if (m_nmi) begin
            m_epc = bk_epc_q.pop_back();
            m_pie = bk_pie_q.pop_back();
            m_nmi = 1'b0;
         end else begin
            m_pie = 1'b1;
         end
      end else if (c_we) begin
         case (c_addr)
            12'h300: begin m_gie = c_wd[3]; m_pie = c_wd[7]; end
            12'h304: m_ie = c_wd[15:0];
            12'h305: m_vec = {c_wd[31:8], 8'h00};
            12'h341: m_epc = c_wd;
            default: ;
         endcase
      end
   endtask

   task automatic cyc(input logic en, input logic nmi, input logic [31:0] pc,
                      input logic ret, input logic we, input logic [11:0] a,
                      input logic [31:0] wd);
      @(negedge clk);
      t_en = en; t_nmi = nmi; t_pc = pc; t_ret = ret;
      c_we = we; c_addr = a; c_wd = wd;
      #1 compare_all();
      @(posedge clk);
      model_step();
   endtask

   task automatic idle(input logic [11:0] a);
      cyc(1'b0, 1'b0, 32'h0, 1'b0, 1'b0, a, 32'h0);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] wd);
      cyc(1'b0, 1'b0, 32'h0, 1'b0, 1'b1, a, wd);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      m_epc = '0; m_gie = 1'b0; m_pie = 1'b0; m_nmi = 1'b0; m_ie = '0;
      m_vec = 32'h8000_1200;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      cur_req = "R1";
      idle(12'h300); idle(12'h305);

      cur_req = "R5";
      wr(12'h300, 32'hFFFF_FF88); idle(12'h300);
      wr(12'h304, 32'hFFFF_FFFF); idle(12'h304);
      wr(12'h341, 32'h0000_0444); idle(12'h341);
      wr(12'h7C0, 32'hDEAD_BEEF); idle(12'h7C0); idle(12'h300);

      cur_req = "R6";
      wr(12'h305, 32'h1234_56FF); idle(12'h305);

      cur_req = "R2";
      cyc(1'b1, 1'b0, 32'h0000_2000, 1'b0, 1'b0, 12'h341, 32'h0);
      cur_req = "R3";
      idle(12'h300);

      cur_req = "R4";
      cyc(1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 12'h300, 32'h0);
      idle(12'h300);
      wr(12'h300, 32'h0000_0008);
      cyc(1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 12'h300, 32'h0);
      idle(12'h300);

      cur_req = "R7";
      wr(12'h300, 32'h0000_0008);
      cyc(1'b1, 1'b0, 32'h0000_3000, 1'b0, 1'b1, 12'h300, 32'h0000_0088);
      idle(12'h300);
      cyc(1'b1, 1'b0, 32'h0000_3100, 1'b1, 1'b0, 12'h300, 32'h0);
      idle(12'h300);
      cyc(1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 12'h341, 32'h0000_0999);
      idle(12'h341);

      cur_req = "R8";
      wr(12'h300, 32'h0000_0088);
      cyc(1'b1, 1'b0, 32'h0000_4000, 1'b0, 1'b0, 12'h300, 32'h0);
      wr(12'h300, 32'h0000_0008);
      cyc(1'b1, 1'b1, 32'h0000_5000, 1'b0, 1'b0, 12'h300, 32'h0);
      idle(12'h300);

      cur_req = "R9";
      cyc(1'b1, 1'b0, 32'h0000_6000, 1'b0, 1'b0, 12'h341, 32'h0);
      cyc(1'b1, 1'b1, 32'h0000_7000, 1'b0, 1'b0, 12'h300, 32'h0);
      idle(12'h341);

      cur_req = "R10";
      cyc(1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 12'h300, 32'h0);
      idle(12'h300); idle(12'h341);
      cur_req = "R4";
      cyc(1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 12'h300, 32'h0);
      idle(12'h300);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule